// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer. Software reaches it through a small register interface with byte enables. The interface has a control word, a counter, a timeout limit and a refresh window. A counter advances on pulses from one of four tick sources. Whenever the counter reaches the timeout limit, the block sets a sticky expiry flag and drives a reset request for a fixed number of bus cycles.

Two operations are guarded. Each needs a pair of key words written back to back to the counter offset:

- A refresh pair clears the counter.
- An unlock pair opens the configuration registers for a short span of bus cycles.

A malformed key sequence raises the reset request at once. This covers a wrong word, a second word that arrives too late, or a refresh made too early while a window is set. When configuration is written with the re-update bit clear, the configuration is frozen until the next system reset.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, offset 0x0 reads 0x0000_0020, the counter (0x4) reads 0, the limit (0x8) reads the parameter default 0x0000_FFFF, the window (0xC) reads 0, and the reset request is low. Offset 0x0 packs two bytes:
  - Byte 0: bit 7 is the run enable and bit 5 is the re-update permission.
  - Byte 1: bit 14 is the expiry flag and bits 9:8 are the tick source.
- R2: Writes to the run enable, re-update bit, tick source, limit and window take effect only during a 128-cycle window. The window opens once the word 0x0000_C520 and then 0x0000_D928 are written to offset 0x4. A write k cycles after the second unlock word is accepted for k ≤ 128 and ignored for k = 129. Writes to 0x4, 0x8 and 0xC count only with all four byte enables set.
- R3: An accepted byte-0 write with bit 5 clear freezes all configuration until reset, even after a later unlock.
- R4: The counter advances only while the run enable is set and the selected source pulses. The tick source field selects as follows: 0 is every bus cycle, 1 is tick_lpo_i, 2 is tick_32k_i and 3 is tick_ext_i. Pulses on the other sources have no effect.
- R5: Writing 0x0000_A602 and then 0x0000_B480 to offset 0x4 clears the counter.
- R6: The second word of a pair must arrive within 16 cycles of the first. If it arrives 16 cycles after the first it is accepted. If no word has arrived by then, the reset request rises at the 16th cycle edge.
- R7: Any full-word write to offset 0x4 that is not a valid next key word raises the reset request on the next cycle. A partial-width write there is ignored.
- R8: When a tick brings the counter to the limit, the expiry flag is set and the reset request is high for exactly 8 cycles, starting in the same cycle. The counter then holds at the limit.
- R9: Writing 1 to bit 14 with byte lane 1 enabled clears the expiry flag, with no unlock needed.
- R10: With a nonzero window, a refresh made while the counter is below the window raises the reset request and leaves the counter unchanged. A refresh at or above the window clears the counter. A window of 0 disables this check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write byte offset (0x0, 0x4, 0x8, 0xC) |
| wr_be_i | input | 4 | Write byte enables |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| tick_lpo_i | input | 1 | Low-power tick enable strobe |
| tick_32k_i | input | 1 | 32 kHz tick enable strobe |
| tick_ext_i | input | 1 | External tick enable strobe |
| wdt_rst_o | output | 1 | Reset request |
| wdt_flag_o | output | 1 | Expiry flag |

## Verification
The hardest conditions to reach from the ports are the exact cycle boundaries of the two timing rules. These are the 16-cycle gap between key words and the 128-cycle configuration window, each probed one cycle on either side of its limit. The bench counts idle falling edges after the write that opens each interval. It then places the closing write or the sampling point precisely on the boundary edge and on the edge after it. The windowed-refresh error needs the counter held at a known value below and then at the window. The bench therefore runs the counter from the external tick source, which it alone pulses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [31:0] KEY_REFRESH_FIRST  = 32'h0000_A602;
    localparam logic [31:0] KEY_REFRESH_SECOND = 32'h0000_B480;
    localparam logic [31:0] KEY_UNLOCK_FIRST   = 32'h0000_C520;
    localparam logic [31:0] KEY_UNLOCK_SECOND  = 32'h0000_D928;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_COUNT = 4'h4;
    localparam logic [3:0] OFS_LIMIT = 4'h8;
    localparam logic [3:0] OFS_WIN   = 4'hC;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_WAIT_REFRESH,
        KS_WAIT_UNLOCK
    } key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int GAP_CYC = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic [31:0] data_i,
    output logic        refresh_o,
    output logic        unlock_o,
    output logic        error_o
);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        key_state_e    st;
        logic [GW-1:0] gap;
    } ks_t;

    ks_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        refresh_o = 1'b0;
        unlock_o  = 1'b0;
        error_o   = 1'b0;
        unique case (s_q.st)
            KS_IDLE: begin
                if (wr_i) begin
                    s_d.gap = '0;
                    if (data_i == KEY_REFRESH_FIRST)     s_d.st = KS_WAIT_REFRESH;
                    else if (data_i == KEY_UNLOCK_FIRST) s_d.st = KS_WAIT_UNLOCK;
                    else                                 error_o = 1'b1;
                end
            end
            KS_WAIT_REFRESH, KS_WAIT_UNLOCK: begin
                if (wr_i) begin
                    s_d.st  = KS_IDLE;
                    s_d.gap = '0;
                    if (s_q.st == KS_WAIT_REFRESH && data_i == KEY_REFRESH_SECOND)
                        refresh_o = 1'b1;
                    else if (s_q.st == KS_WAIT_UNLOCK && data_i == KEY_UNLOCK_SECOND)
                        unlock_o = 1'b1;
                    else
                        error_o = 1'b1;
                end else if (s_q.gap == GW'(GAP_CYC - 1)) begin
                    // second word missed its slot
                    error_o = 1'b1;
                    s_d.st  = KS_IDLE;
                    s_d.gap = '0;
                end else begin
                    s_d.gap = s_q.gap + 1'b1;
                end
            end
            default: s_d.st = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: KS_IDLE, gap: '0};
        else         s_q <= s_d;
    end
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
    parameter int NSRC = 4,
    localparam int SW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] src_i,
    input  logic [SW-1:0]   sel_i,
    output logic            tick_o
);
    assign tick_o = src_i[sel_i];
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int LEN = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rst_o
);
    localparam int LW = $clog2(LEN + 1);

    typedef struct packed {
        logic [LW-1:0] left;
    } rp_t;

    rp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trig_i)              s_d.left = LW'(LEN);
        else if (s_q.left != '0) s_d.left = s_q.left - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{left: '0};
        else         s_q <= s_d;
    end

    assign rst_o = (s_q.left != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int LIMIT_RST = 16'hFFFF,
    parameter int OPEN_CYC  = 128,
    parameter int GAP_CYC   = 16,
    parameter int RST_LEN   = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [3:0]  wr_addr_i,
    input  logic [3:0]  wr_be_i,
    input  logic [31:0] wr_data_i,
    input  logic [3:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    input  logic        tick_lpo_i,
    input  logic        tick_32k_i,
    input  logic        tick_ext_i,
    output logic        wdt_rst_o,
    output logic        wdt_flag_o
);
    localparam int OW = $clog2(OPEN_CYC + 1);

    typedef struct packed {
        logic             run;
        logic             upd;
        logic             flag;
        logic [1:0]       src;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] win;
        logic [OW-1:0]    open;
        logic             locked;
    } wdt_t;

    wdt_t s_d, s_q;

    logic             full_wr, key_wr, cfg_ok;
    logic             refresh, unlock, key_err, win_err, expire, rst_trig;
    logic             tick;
    logic [CNT_W-1:0] cnt_inc;

    assign full_wr = wr_en_i && (wr_be_i == 4'hF);
    assign key_wr  = full_wr && (wr_addr_i == OFS_COUNT);

    wdt_key_seq #(.GAP_CYC(GAP_CYC)) u_key (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (key_wr),
        .data_i    (wr_data_i),
        .refresh_o (refresh),
        .unlock_o  (unlock),
        .error_o   (key_err)
    );

    wdt_tick_sel #(.NSRC(4)) u_tick (
        .src_i  ({tick_ext_i, tick_32k_i, tick_lpo_i, 1'b1}),
        .sel_i  (s_q.src),
        .tick_o (tick)
    );

    always_comb begin
        s_d     = s_q;
        cfg_ok  = (s_q.open != '0) && !s_q.locked;
        cnt_inc = s_q.cnt + 1'b1;
        expire  = 1'b0;
        win_err = refresh && (s_q.win != '0) && (s_q.cnt < s_q.win);

        // configuration window
        if (unlock)                s_d.open = OW'(OPEN_CYC);
        else if (s_q.open != '0)   s_d.open = s_q.open - 1'b1;

        // counter
        if (refresh && !win_err) begin
            s_d.cnt = '0;
        end else if (s_q.run && tick && (s_q.cnt < s_q.limit)) begin
            s_d.cnt = cnt_inc;
            expire  = (cnt_inc == s_q.limit);
        end

        // expiry flag: set dominates write-one-to-clear
        if (expire)
            s_d.flag = 1'b1;
        else if (wr_en_i && wr_addr_i == OFS_CTRL && wr_be_i[1] && wr_data_i[14])
            s_d.flag = 1'b0;

        // guarded configuration
        if (cfg_ok && wr_en_i) begin
            unique case (wr_addr_i)
                OFS_CTRL: begin
                    if (wr_be_i[0]) begin
                        s_d.run = wr_data_i[7];
                        s_d.upd = wr_data_i[5];
                        if (!wr_data_i[5]) s_d.locked = 1'b1;
                    end
                    if (wr_be_i[1]) s_d.src = wr_data_i[9:8];
                end
                OFS_LIMIT: if (full_wr) s_d.limit = wr_data_i[CNT_W-1:0];
                OFS_WIN:   if (full_wr) s_d.win   = wr_data_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{run: 1'b0, upd: 1'b1, flag: 1'b0, src: 2'd0, cnt: '0,
                     limit: CNT_W'(LIMIT_RST), win: '0, open: '0, locked: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_trig = expire || key_err || win_err;

    wdt_rst_pulse #(.LEN(RST_LEN)) u_pulse (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (rst_trig),
        .rst_o  (wdt_rst_o)
    );

    always_comb begin
        unique case (rd_addr_i)
            OFS_CTRL:  rd_data_o = {16'h0, 1'b0, s_q.flag, 4'h0, s_q.src,
                                    s_q.run, 1'b0, s_q.upd, 5'h0};
            OFS_COUNT: rd_data_o = 32'(s_q.cnt);
            OFS_LIMIT: rd_data_o = 32'(s_q.limit);
            OFS_WIN:   rd_data_o = 32'(s_q.win);
            default:   rd_data_o = 32'h0;
        endcase
    end

    assign wdt_flag_o = s_q.flag;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W   = 16,
    parameter int RST_LEN = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rst_i,
    input logic             flag_i,
    input logic             tick_i,
    input logic             refresh_i,
    input logic             win_err_i,
    input logic             key_err_i,
    input logic             trig_i,
    input logic             locked_i,
    input logic [CNT_W-1:0] cnt_i
);
    localparam int RW = $clog2(RST_LEN + 1);

    // independent model of how long the reset request has been up since its last trigger
    logic [RW-1:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    run_q <= '0;
        else if (trig_i)                run_q <= RW'(1);
        else if (run_q == RW'(RST_LEN)) run_q <= '0;
        else if (run_q != '0)           run_q <= run_q + 1'b1;
    end

    a_r8_rst_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_i == (run_q != '0));

    a_r8_flag_with_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> rst_i);

    a_r7_key_err_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_err_i |=> rst_i);

    a_r10_window_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_err_i |=> rst_i);

    a_r5_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_i && !win_err_i |=> cnt_i == '0);

    a_r4_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i && !refresh_i |=> $stable(cnt_i));

    a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |=> locked_i);
endmodule

bind keyed_wdt wdt_checker #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_wdt_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_i     (wdt_rst_o),
    .flag_i    (wdt_flag_o),
    .tick_i    (tick),
    .refresh_i (refresh),
    .win_err_i (win_err),
    .key_err_i (key_err),
    .trig_i    (rst_trig),
    .locked_i  (s_q.locked),
    .cnt_i     (s_q.cnt)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    // time unit taken as 1 ns: 4 ns period, 250 MHz
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = 4'h0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = 32'h0;
    logic [3:0]  rd_addr = 4'h0;
    logic [31:0] rd_data;
    logic        t_lpo = 1'b0, t_32k = 1'b0, t_ext = 1'b0;
    logic        wdt_rst, wdt_flag;

    always #2 clk = ~clk;

    keyed_wdt u_keyed_wdt (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_be_i    (wr_be),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .tick_lpo_i (t_lpo),
        .tick_32k_i (t_32k),
        .tick_ext_i (t_ext),
        .wdt_rst_o  (wdt_rst),
        .wdt_flag_o (wdt_flag)
    );

    typedef struct {
        int          kind;   // 0: register read, 1: reset request
        logic [3:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_pend = 0;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin : monitor
        forever begin
            item_t       it;
            logic [31:0] act;
            wait (n_pend != 0);
            it = sb_q.pop_front();
            rd_addr = it.addr;
            #1;
            act = (it.kind == 0) ? rd_data : {31'h0, wdt_rst};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
            n_pend--;
        end
    end

    // driver side: every expectation consumes one falling edge after it is checked
    task automatic push_item(input int k, input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = k; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        n_pend++;
        wait (n_pend == 0);
        @(negedge clk);
    endtask

    task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        push_item(0, a, e, tag);
    endtask

    task automatic exp_rst(input logic e, input string tag);
        push_item(1, 4'h0, {31'h0, e}, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int src, input int n);
        repeat (n) begin
            if (src == 1) t_lpo = 1'b1;
            if (src == 2) t_32k = 1'b1;
            if (src == 3) t_ext = 1'b1;
            @(negedge clk);
            t_lpo = 1'b0; t_32k = 1'b0; t_ext = 1'b0;
        end
    endtask

    task automatic do_unlock();
        wr(4'h4, 32'h0000_C520, 4'hF);
        wr(4'h4, 32'h0000_D928, 4'hF);
    endtask

    task automatic do_refresh();
        wr(4'h4, 32'h0000_A602, 4'hF);
        wr(4'h4, 32'h0000_B480, 4'hF);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : driver
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_reg(4'h0, 32'h0000_0020, "R1 ctrl");
        exp_reg(4'h4, 32'h0, "R1 count");
        exp_reg(4'h8, 32'h0000_FFFF, "R1 limit");
        exp_reg(4'hC, 32'h0, "R1 window");
        exp_rst(1'b0, "R1 rst");

        // R2 locked before unlock
        wr(4'h8, 32'h55, 4'hF);
        exp_reg(4'h8, 32'h0000_FFFF, "R2 write without unlock");

        // R2/R4 configure after unlock
        do_unlock();
        wr(4'h0, 32'h0000_0300, 4'b0010);
        pulse(3, 2);
        exp_reg(4'h4, 32'h0, "R4 run enable clear");
        wr(4'h8, 32'd10, 4'hF);
        wr(4'h0, 32'h0000_00A0, 4'b0001);
        exp_reg(4'h0, 32'h0000_03A0, "R2 ctrl accepted");
        exp_reg(4'h8, 32'd10, "R2 limit accepted");
        pulse(1, 2);
        pulse(2, 1);
        exp_reg(4'h4, 32'h0, "R4 unselected ticks");
        pulse(3, 3);
        exp_reg(4'h4, 32'd3, "R4 selected ticks");

        // R5 refresh
        do_refresh();
        exp_reg(4'h4, 32'h0, "R5 counter cleared");
        exp_rst(1'b0, "R5 no reset");

        // R6 gap boundary
        pulse(3, 2);
        wr(4'h4, 32'h0000_A602, 4'hF);
        idle(15);
        wr(4'h4, 32'h0000_B480, 4'hF);
        exp_reg(4'h4, 32'h0, "R6 second word at 16 cycles");
        exp_rst(1'b0, "R6 second word at 16 cycles");
        wr(4'h4, 32'h0000_A602, 4'hF);
        idle(15);
        exp_rst(1'b0, "R6 before gap expiry");
        exp_rst(1'b1, "R6 gap expired");
        idle(10);
        exp_rst(1'b0, "R6 pulse ended");

        // R7 wrong words
        wr(4'h4, 32'h0000_1234, 4'hF);
        exp_rst(1'b1, "R7 stray word");
        idle(10);
        wr(4'h4, 32'h0000_A602, 4'hF);
        wr(4'h4, 32'h0000_1111, 4'hF);
        exp_rst(1'b1, "R7 wrong second word");
        idle(10);
        wr(4'h4, 32'h0000_1234, 4'b0011);
        idle(20);
        exp_rst(1'b0, "R7 partial write ignored");

        // R8 timeout
        pulse(3, 9);
        exp_reg(4'h4, 32'd9, "R8 before limit");
        exp_reg(4'h0, 32'h0000_03A0, "R8 flag clear before limit");
        pulse(3, 1);
        repeat (8) exp_rst(1'b1, "R8 reset pulse high");
        exp_rst(1'b0, "R8 reset pulse length");
        exp_reg(4'h0, 32'h0000_43A0, "R8 flag set");
        pulse(3, 2);
        exp_reg(4'h4, 32'd10, "R8 counter holds at limit");

        // R9 flag clear
        wr(4'h0, 32'h0000_4300, 4'b0010);
        exp_reg(4'h0, 32'h0000_03A0, "R9 flag cleared");

        // R10 window
        do_unlock();
        wr(4'hC, 32'd5, 4'hF);
        exp_reg(4'hC, 32'd5, "R10 window set");
        do_refresh();
        exp_reg(4'h4, 32'h0, "R10 refresh above window");
        exp_rst(1'b0, "R10 refresh above window");
        do_refresh();
        exp_rst(1'b1, "R10 early refresh at 0");
        idle(10);
        pulse(3, 4);
        do_refresh();
        exp_rst(1'b1, "R10 early refresh at 4");
        exp_reg(4'h4, 32'd4, "R10 early refresh keeps counter");
        idle(10);
        pulse(3, 1);
        do_refresh();
        exp_rst(1'b0, "R10 refresh at window");
        exp_reg(4'h4, 32'h0, "R10 refresh at window clears");

        // R2 open-window boundary
        do_unlock();
        idle(127);
        wr(4'hC, 32'd0, 4'hF);
        exp_reg(4'hC, 32'h0, "R2 write at cycle 128");
        do_unlock();
        idle(128);
        wr(4'hC, 32'd7, 4'hF);
        exp_reg(4'hC, 32'h0, "R2 write at cycle 129 ignored");

        // R3 freeze
        do_unlock();
        wr(4'h0, 32'h0000_0080, 4'b0001);
        exp_reg(4'h0, 32'h0000_0380, "R3 freezing write");
        do_unlock();
        wr(4'h8, 32'd3, 4'hF);
        wr(4'h0, 32'h0000_00A0, 4'b0001);
        exp_reg(4'h8, 32'd10, "R3 limit frozen");
        exp_reg(4'h0, 32'h0000_0380, "R3 ctrl frozen");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule